// File: doc/BRIEF.md
# Command List Processor

The block walks a list of 32-bit words held in a word-addressed memory and turns it into masked writes on a local bank of 32-bit registers. Every command starts with its payload word, followed by a header word. The header names a target register, gives a four-bit byte-lane enable and a count of further payload words, and carries a flag that picks between two burst styles. In one style every further word goes to the same register. In the other, each further word goes to the next register up.

Each accepted write merges the payload into the old contents under the byte lanes and pulses a strobe that carries the register index, so downstream logic can react to it. Two register slots act as jump triggers. Writing one of them makes the engine drop the rest of the current list and carry on from a secondary buffer, whose word address and word count were loaded earlier into configuration registers. A start pulse loads the first list's address and length. A done pulse marks the end of the work.

Top module: `cmdlist_engine`

## Requirements
- R1: Each command is read as one payload word and then one header word, from consecutive addresses. Header fields: target register in bits 15:0, byte-lane enable in bits 19:16, count of further payload words in bits 27:20, burst-increment flag in bit 31.
- R2: Before each command starts, an odd word index is raised by one, so every command starts on an even word.
- R3: With bit 31 clear, the first payload word and every further word are all written to the same target register.
- R4: With bit 31 set, further word k (counting from 0) is written to target register + k + 1.
- R5: Enable bit n covers data bits 8n+7:8n. The stored result is (old AND NOT lanes) OR (payload AND lanes), and one header's lanes apply to every word of its burst.
- R6: A write to a register index at or above REG_COUNT (default 768) changes no register and gives no strobe. It sets range_err, which stays high until the next accepted start.
- R7: Writing register 0x23C or 0x23D jumps to buffer 0 or buffer 1. The new list address is taken from register 0x23A or 0x23B, and its word count from register 0x238 or 0x239. Any further words of the triggering burst are dropped, and fetching restarts at word 0 of the new list.
- R8: At a command boundary, once realignment is done, an index at or past the list length ends the work. done is high for exactly one cycle and then busy is low. A zero length ends at once with no reads.
- R9: Every accepted write gives a one-cycle wr_strobe carrying its wr_index. The merged value can be read on rd_data from that cycle on.
- R10: After reset, busy, done, mem_req and range_err are low and all registers read zero. mem_req is a one-cycle pulse with at most one read outstanding, and the engine waits any number of cycles for mem_rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a list; taken only while idle |
| start_addr | input | AW | Word address of the first list |
| start_len | input | LW | Length of the first list in words |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | AW | Word address of the request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| wr_strobe | output | 1 | Pulse for each accepted register write |
| wr_index | output | IW | Register written by the pulsed write |
| rd_index | input | IW | Register read select |
| rd_data | output | 32 | Contents of the selected register (zero if out of range) |
| busy | output | 1 | Engine is working through a list |
| done | output | 1 | One-cycle end-of-work pulse |
| range_err | output | 1 | Sticky out-of-range write flag |

## Verification
A register write is committed on the clock edge that ends the write cycle. wr_strobe and the merged contents on rd_data appear together one cycle after that write cycle. done follows the final write or read by two cycles, once the boundary check has run. The bench drives at falling edges and records strobes at falling edges, and its memory model answers each request after a latency that depends on the address. The expected register contents, strobe counts and flags are therefore compared only after done has been seen, so no check depends on the exact number of fetch cycles. The single-cycle width of done and of mem_req is checked on consecutive falling edges.

// File: rtl/cmdlist_pkg.sv
package cmdlist_pkg;

    localparam int DEF_REG_COUNT = 768;
    localparam int DEF_NUM_BUF   = 2;
    localparam int BUF_SIZE_ID   = 'h238;
    localparam int BUF_ADDR_ID   = 'h23A;
    localparam int TRIG_ID       = 'h23C;

    typedef struct packed {
        logic        incr;
        logic [2:0]  spare;
        logic [7:0]  more;
        logic [3:0]  lanes;
        logic [15:0] target;
    } cmd_hdr_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CHECK, ST_REQ, ST_WAIT, ST_WR, ST_FIN
    } eng_state_t;

    typedef enum logic [1:0] {
        PH_VAL, PH_HDR, PH_EXT
    } word_phase_t;

    function automatic logic [31:0] lanes_to_bits(input logic [3:0] lanes);
        logic [31:0] m;
        for (int b = 0; b < 4; b++) begin
            m[8*b +: 8] = {8{lanes[b]}};
        end
        return m;
    endfunction

    function automatic logic [31:0] merge_word(input logic [31:0] old_v,
                                               input logic [31:0] new_v,
                                               input logic [3:0]  lanes);
        logic [31:0] m;
        m = lanes_to_bits(lanes);
        return (old_v & ~m) | (new_v & m);
    endfunction

endpackage

// File: rtl/cmdlist_regfile.sv
module cmdlist_regfile
    import cmdlist_pkg::*;
#(
    parameter int REG_COUNT = DEF_REG_COUNT,
    parameter int AW        = 16,
    parameter int LW        = 16,
    parameter int NUM_BUF   = DEF_NUM_BUF,
    parameter int IW        = $clog2(REG_COUNT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [16:0]   wr_id,
    input  logic [31:0]   wr_data,
    input  logic [3:0]    wr_lanes,
    input  logic          clr_err,
    input  logic [IW-1:0] rd_index,
    output logic [31:0]   rd_data,
    output logic [AW-1:0] cfg_addr [NUM_BUF],
    output logic [LW-1:0] cfg_size [NUM_BUF],
    output logic          wr_strobe,
    output logic [IW-1:0] wr_index,
    output logic          range_err
);

    localparam logic [16:0] CNT17 = 17'(REG_COUNT);
    localparam logic [IW:0] CNTW  = (IW+1)'(REG_COUNT);

    logic [31:0] regs [REG_COUNT];
    logic        in_range;
    logic [IW-1:0] slot;

    assign in_range = wr_id < CNT17;
    assign slot     = wr_id[IW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < REG_COUNT; i++) begin
                regs[i] <= '0;
            end
            wr_strobe <= 1'b0;
            wr_index  <= '0;
            range_err <= 1'b0;
        end else begin
            wr_strobe <= 1'b0;
            if (clr_err) begin
                range_err <= 1'b0;
            end
            if (wr_en) begin
                if (in_range) begin
                    regs[slot] <= merge_word(regs[slot], wr_data, wr_lanes);
                    wr_strobe  <= 1'b1;
                    wr_index   <= slot;
                end else begin
                    range_err <= 1'b1;
                end
            end
        end
    end

    assign rd_data = ({1'b0, rd_index} < CNTW) ? regs[rd_index] : 32'h0;

    for (genvar b = 0; b < NUM_BUF; b++) begin : g_cfg
        assign cfg_addr[b] = regs[BUF_ADDR_ID + b][AW-1:0];
        assign cfg_size[b] = regs[BUF_SIZE_ID + b][LW-1:0];
    end

    AST_RANGE_DISCARD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !(wr_id < CNT17)) |=> !wr_strobe) else $error("discard"); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (range_err && !clr_err) |=> range_err) else $error("sticky"); // R6
    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (wr_strobe && !wr_en) |=> !wr_strobe) else $error("strobe"); // R9

endmodule

// File: rtl/cmdlist_fetch.sv
module cmdlist_fetch
    import cmdlist_pkg::*;
#(
    parameter int AW      = 16,
    parameter int LW      = 16,
    parameter int NUM_BUF = DEF_NUM_BUF,
    parameter int SELW    = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [LW-1:0] start_len,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [31:0]   mem_rdata,
    input  logic [AW-1:0] cfg_addr [NUM_BUF],
    input  logic [LW-1:0] cfg_size [NUM_BUF],
    output logic          wr_en,
    output logic [16:0]   wr_id,
    output logic [31:0]   wr_data,
    output logic [3:0]    wr_lanes,
    output logic          clr_err,
    output logic          busy,
    output logic          done
);

    localparam logic [16:0] TRIG_LO = 17'(TRIG_ID);
    localparam logic [16:0] TRIG_HI = 17'(TRIG_ID + NUM_BUF);

    eng_state_t  state;
    word_phase_t phase;
    logic [AW-1:0] base;
    logic [LW-1:0] len;
    logic [LW:0]   idx;
    logic [LW:0]   idx_al;
    logic [15:0]   tgt;
    logic [3:0]    lanes;
    logic          incr;
    logic [7:0]    rem;
    logic [7:0]    off;
    logic [31:0]   value;
    logic          trig_hit;
    logic [SELW-1:0] trig_sel;
    cmd_hdr_t      hdr_in;

    assign hdr_in   = cmd_hdr_t'(mem_rdata);
    assign idx_al   = idx + {{LW{1'b0}}, idx[0]};
    assign wr_en    = (state == ST_WR);
    assign wr_id    = {1'b0, tgt} + {9'b0, off};
    assign wr_data  = value;
    assign wr_lanes = lanes;
    assign trig_hit = (wr_id >= TRIG_LO) && (wr_id < TRIG_HI);
    assign trig_sel = SELW'(wr_id - TRIG_LO);
    assign mem_req  = (state == ST_REQ);
    assign mem_addr = base + AW'(idx);
    assign clr_err  = start && (state == ST_IDLE);
    assign busy     = (state != ST_IDLE);
    assign done     = (state == ST_FIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            phase <= PH_VAL;
            base  <= '0;
            len   <= '0;
            idx   <= '0;
            tgt   <= '0;
            lanes <= '0;
            incr  <= 1'b0;
            rem   <= '0;
            off   <= '0;
            value <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    base  <= start_addr;
                    len   <= start_len;
                    idx   <= '0;
                    state <= ST_CHECK;
                end
                ST_CHECK: begin
                    idx <= idx_al;
                    if (idx_al >= {1'b0, len}) begin
                        state <= ST_FIN;
                    end else begin
                        phase <= PH_VAL;
                        state <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    idx   <= idx + 1'b1;
                    state <= ST_WAIT;
                end
                ST_WAIT: if (mem_rvalid) begin
                    unique case (phase)
                        PH_VAL: begin
                            value <= mem_rdata;
                            phase <= PH_HDR;
                            state <= ST_REQ;
                        end
                        PH_HDR: begin
                            tgt   <= hdr_in.target;
                            lanes <= hdr_in.lanes;
                            incr  <= hdr_in.incr;
                            rem   <= hdr_in.more;
                            off   <= '0;
                            state <= ST_WR;
                        end
                        default: begin
                            value <= mem_rdata;
                            state <= ST_WR;
                        end
                    endcase
                end
                ST_WR: begin
                    if (trig_hit) begin
                        base  <= cfg_addr[trig_sel];
                        len   <= cfg_size[trig_sel];
                        idx   <= '0;
                        state <= ST_CHECK;
                    end else if (rem != 8'd0) begin
                        rem   <= rem - 8'd1;
                        if (incr) begin
                            off <= off + 8'd1;
                        end
                        phase <= PH_EXT;
                        state <= ST_REQ;
                    end else begin
                        state <= ST_CHECK;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_CMD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_REQ && phase == PH_VAL) |-> !idx[0]) else $error("align"); // R2
    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req) else $error("req"); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy)) else $error("done"); // R8
    AST_REPEAT_SAME: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !incr) |-> (off == 8'd0)) else $error("repeat"); // R3

endmodule

// File: rtl/cmdlist_engine.sv
module cmdlist_engine
    import cmdlist_pkg::*;
#(
    parameter int REG_COUNT = DEF_REG_COUNT,
    parameter int AW        = 16,
    parameter int LW        = 16,
    parameter int NUM_BUF   = DEF_NUM_BUF,
    parameter int IW        = $clog2(REG_COUNT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [LW-1:0] start_len,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [31:0]   mem_rdata,
    output logic          wr_strobe,
    output logic [IW-1:0] wr_index,
    input  logic [IW-1:0] rd_index,
    output logic [31:0]   rd_data,
    output logic          busy,
    output logic          done,
    output logic          range_err
);

    logic          wr_en;
    logic [16:0]   wr_id;
    logic [31:0]   wr_data;
    logic [3:0]    wr_lanes;
    logic          clr_err;
    logic [AW-1:0] cfg_addr [NUM_BUF];
    logic [LW-1:0] cfg_size [NUM_BUF];

    cmdlist_fetch #(.AW(AW), .LW(LW), .NUM_BUF(NUM_BUF)) u_fetch (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .start_len(start_len), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .cfg_addr(cfg_addr), .cfg_size(cfg_size), .wr_en(wr_en),
        .wr_id(wr_id), .wr_data(wr_data), .wr_lanes(wr_lanes),
        .clr_err(clr_err), .busy(busy), .done(done)
    );

    cmdlist_regfile #(.REG_COUNT(REG_COUNT), .AW(AW), .LW(LW),
                      .NUM_BUF(NUM_BUF), .IW(IW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_id(wr_id),
        .wr_data(wr_data), .wr_lanes(wr_lanes), .clr_err(clr_err),
        .rd_index(rd_index), .rd_data(rd_data), .cfg_addr(cfg_addr),
        .cfg_size(cfg_size), .wr_strobe(wr_strobe), .wr_index(wr_index),
        .range_err(range_err)
    );

    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy) else $error("start"); // R8

endmodule

// File: tb/test_cmdlist_engine.sv
module test_cmdlist_engine;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [15:0] start_addr;
    logic [15:0] start_len;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic        wr_strobe;
    logic [9:0]  wr_index;
    logic [9:0]  rd_index;
    logic [31:0] rd_data;
    logic        busy;
    logic        done;
    logic        range_err;

    int checks = 0;
    int errors = 0;
    int nstb = 0;
    int req_viol = 0;
    int lat = 0;
    logic [9:0]  stb_log [16];
    logic [31:0] mem [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    cmdlist_engine i_cmdlist_engine (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .start_len(start_len), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .wr_strobe(wr_strobe), .wr_index(wr_index), .rd_index(rd_index),
        .rd_data(rd_data), .busy(busy), .done(done), .range_err(range_err)
    );

    // memory model: answers one request after an address-dependent delay
    logic        pend = 1'b0;
    logic [7:0]  paddr = '0;
    int          wait_c = 0;
    logic        prev_req = 1'b0;
    always @(negedge clk) begin
        if (rst) begin
            pend       <= 1'b0;
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
        end else begin
            mem_rvalid <= 1'b0;
            if (mem_req) begin
                pend   <= 1'b1;
                paddr  <= mem_addr[7:0];
                wait_c <= lat + int'(mem_addr[0]);
            end else if (pend) begin
                if (wait_c == 0) begin
                    mem_rvalid <= 1'b1;
                    mem_rdata  <= mem[paddr];
                    pend       <= 1'b0;
                end else begin
                    wait_c <= wait_c - 1;
                end
            end
        end
        if (wr_strobe) begin
            if (nstb < 16) stb_log[nstb] = wr_index;
            nstb = nstb + 1;
        end
        if (!rst && mem_req && prev_req) req_viol = req_viol + 1;
        prev_req = mem_req;
    end

    function automatic logic [31:0] hdr(input logic [15:0] id, input logic [3:0] lanes,
                                        input logic [7:0] more, input logic incr);
        return {incr, 3'b000, more, lanes, id};
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic read_reg(input logic [9:0] idx, output logic [31:0] val);
        rd_index = idx;
        #1;
        val = rd_data;
    endtask

    task automatic chk_reg(input logic [9:0] idx, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        read_reg(idx, v);
        chk(v === exp, tag, v, exp);
    endtask

    task automatic run_list(input logic [15:0] a, input logic [15:0] n);
        logic got;
        @(negedge clk);
        nstb       = 0;
        start_addr = a;
        start_len  = n;
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got = 1'b0;
        for (int k = 0; k < 3000; k++) begin
            if (done) begin
                got = 1'b1;
                break;
            end
            @(negedge clk);
        end
        chk(got, "R8 done reached", 32'(got), 32'd1);
    endtask

    task automatic t_reset();
        chk(busy === 1'b0, "R10 busy after reset", 32'(busy), 0);
        chk(done === 1'b0, "R10 done after reset", 32'(done), 0);
        chk(mem_req === 1'b0, "R10 mem_req after reset", 32'(mem_req), 0);
        chk(range_err === 1'b0, "R10 range_err after reset", 32'(range_err), 0);
        chk_reg(10'h005, 32'h0, "R10 register zero after reset");
    endtask

    task automatic t_single();
        lat = 0;
        mem[0] = 32'hA1B2C3D4;
        mem[1] = hdr(16'h0010, 4'hF, 8'd0, 1'b0);
        run_list(16'h0000, 16'd2);
        chk_reg(10'h010, 32'hA1B2C3D4, "R1 payload then header");
        chk(nstb == 1, "R9 one strobe", 32'(nstb), 1);
        chk(stb_log[0] == 10'h010, "R9 strobe index", 32'(stb_log[0]), 32'h10);
    endtask

    task automatic t_lanes();
        lat = 2;
        mem[2] = 32'h11223344;
        mem[3] = hdr(16'h0010, 4'b0101, 8'd0, 1'b0);
        run_list(16'h0002, 16'd2);
        chk_reg(10'h010, 32'hA122C344, "R5 lane merge 0101");
    endtask

    task automatic t_repeat();
        lat = 3;
        mem[8'h20] = 32'h00000001;
        mem[8'h21] = hdr(16'h0020, 4'b0011, 8'd2, 1'b0);
        mem[8'h22] = 32'h12345678;
        mem[8'h23] = 32'h9ABCDEF0;
        run_list(16'h0020, 16'd4);
        chk_reg(10'h020, 32'h0000DEF0, "R3 R5 repeat burst last word low lanes");
        chk_reg(10'h021, 32'h0, "R3 neighbour untouched");
        chk(nstb == 3, "R3 three strobes", 32'(nstb), 3);
        chk(stb_log[2] == 10'h020, "R3 burst stays on target", 32'(stb_log[2]), 32'h20);
    endtask

    task automatic t_incr_align();
        lat = 1;
        mem[8'h40] = 32'h00001111;
        mem[8'h41] = hdr(16'h0030, 4'hF, 8'd1, 1'b1);
        mem[8'h42] = 32'h00002222;
        mem[8'h43] = 32'hDEADBEEF;
        mem[8'h44] = 32'h00005555;
        mem[8'h45] = hdr(16'h0032, 4'hF, 8'd0, 1'b0);
        run_list(16'h0040, 16'd6);
        chk_reg(10'h030, 32'h00001111, "R4 first word at target");
        chk_reg(10'h031, 32'h00002222, "R4 extra word at target+1");
        chk_reg(10'h032, 32'h00005555, "R2 command after odd index realigned");
        chk(nstb == 3, "R2 strobe count", 32'(nstb), 3);
        chk(range_err === 1'b0, "R2 no stray write", 32'(range_err), 0);
    endtask

    task automatic t_range();
        lat = 0;
        mem[8'h60] = 32'hFFFFFFFF;
        mem[8'h61] = hdr(16'h0300, 4'hF, 8'd0, 1'b0);
        mem[8'h62] = 32'h00000007;
        mem[8'h63] = hdr(16'h02FF, 4'hF, 8'd0, 1'b0);
        run_list(16'h0060, 16'd4);
        chk(nstb == 1, "R6 no strobe for index 768", 32'(nstb), 1);
        chk(range_err === 1'b1, "R6 range_err set", 32'(range_err), 1);
        chk_reg(10'h2FF, 32'h00000007, "R6 last valid register written");
        chk_reg(10'h300, 32'h0, "R6 out-of-range read gives zero");
    endtask

    task automatic t_trigger();
        lat = 2;
        mem[8'h80] = 32'h00000002;
        mem[8'h81] = hdr(16'h0238, 4'hF, 8'd2, 1'b1);
        mem[8'h82] = 32'h00000000;
        mem[8'h83] = 32'h000000A0;
        mem[8'h84] = 32'h00000005;
        mem[8'h85] = hdr(16'h023C, 4'hF, 8'd1, 1'b0);
        mem[8'h86] = 32'h00000099;
        mem[8'h87] = 32'h0;
        mem[8'h88] = 32'h00000077;
        mem[8'h89] = hdr(16'h0040, 4'hF, 8'd0, 1'b0);
        mem[8'hA0] = 32'h00004242;
        mem[8'hA1] = hdr(16'h0041, 4'hF, 8'd0, 1'b0);
        run_list(16'h0080, 16'd10);
        chk_reg(10'h041, 32'h00004242, "R7 secondary buffer executed");
        chk_reg(10'h040, 32'h0, "R7 rest of first list skipped");
        chk_reg(10'h23C, 32'h00000005, "R7 burst after trigger dropped");
        chk(nstb == 5, "R7 strobe count", 32'(nstb), 5);
        chk(range_err === 1'b0, "R6 start clears range_err", 32'(range_err), 0);
    endtask

    task automatic t_empty();
        run_list(16'h0000, 16'd0);
        chk(nstb == 0, "R8 empty list writes nothing", 32'(nstb), 0);
        @(negedge clk);
        chk(done === 1'b0, "R8 done one cycle", 32'(done), 0);
        chk(busy === 1'b0, "R8 idle after done", 32'(busy), 0);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors = errors + 1;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        start = 1'b0;
        start_addr = '0;
        start_len = '0;
        rd_index = '0;
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single();
        t_lanes();
        t_repeat();
        t_incr_align();
        t_range();
        t_trigger();
        t_empty();
        chk(req_viol == 0, "R10 single-cycle request", 32'(req_viol), 0);
        finish_run();
    end

endmodule